// File: doc/BRIEF.md
# Jack-Detect Output Routing Controller

This block decides which of three audio outputs (speaker, headphone, line-out) may play, based on two jack-presence inputs. Each presence input is resynchronised, debounced and then compared against a per-input polarity level to decide whether that jack is plugged in. A plugged headphone enables the headphone path and a plugged line-out enables the line-out path. When neither jack is plugged, the speaker is used instead.

The routing result is a three-bit mask. Whenever the computed mask differs from the stored one, the block runs a switch sequence. First it mutes all three paths together and holds them muted for a set number of cycles. Then it unmutes only the selected paths and stores the new mask in the same cycle. A busy flag is high for the whole muted interval. Right after reset the stored mask is empty, so the first evaluation always runs a sequence and sets up routing that matches the current jack state without needing any jack edge.

Top module: `jack_route_ctrl`

## Requirements
- R1: A jack counts as plugged when its debounced level equals its polarity input (`hp_act_lvl` / `lo_act_lvl`). Otherwise it counts as unplugged. Changing a polarity input re-evaluates the routing with no change on the raw pin.
- R2: Mask encoding: bit 0 is speaker, bit 1 is headphone and bit 2 is line-out. A plugged headphone sets bit 1 and a plugged line-out sets bit 2, and both may be set at once.
- R3: When neither jack is plugged, the mask is 3'b001 (speaker only). Any nonzero stored mask has bit 0 set exactly when bits 1 and 2 are both clear.
- R4: While the computed mask equals the stored mask, no mute pin changes level and `busy` stays low.
- R5: On a mask change, all three mute pins are driven low in the cycle after the change is seen. No mute pin rises unless all three pins were low in the previous cycle.
- R6: The all-muted interval lasts exactly `MUTE_HOLD_CYC` cycles, with `busy` high for all of them. `route_mask` updates in the same cycle that the selected pins rise and `busy` falls.
- R7: Mute pins are active low (0 = muted). Whenever `busy` is low and reset has been left, pin k of {`lo_mute_n`, `hp_mute_n`, `spk_mute_n`} equals `route_mask[k]`. In reset, all pins, the mask and `busy` are 0.
- R8: Raw jack pins pass through two synchroniser flops. The debounced level takes a new value only after the synchronised level has differed from it for `DEBOUNCE_CYC` consecutive cycles, so shorter pulses have no effect on routing.
- R9: After reset, with no jack edge at all, the block routes according to the present jack state within 1 + `MUTE_HOLD_CYC` cycles.
- R10: A jack change that arrives during a switch sequence is picked up by a further sequence once the current one ends. The final mask matches the final jack state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hp_det_raw | input | 1 | Raw headphone presence pin |
| lo_det_raw | input | 1 | Raw line-out presence pin |
| hp_act_lvl | input | 1 | Level of `hp_det_raw` that means plugged |
| lo_act_lvl | input | 1 | Level of `lo_det_raw` that means plugged |
| spk_mute_n | output | 1 | Speaker amplifier mute, 0 mutes |
| hp_mute_n | output | 1 | Headphone path mute, 0 mutes |
| lo_mute_n | output | 1 | Line-out path mute, 0 mutes |
| route_mask | output | 3 | Stored output mask {line-out, headphone, speaker} |
| busy | output | 1 | High during the all-muted interval of a switch |

## Verification
The bench targets the speaker fallback. A design that drops it would leave every path muted when both jacks are unplugged, or keep the speaker playing next to a headphone. It sends a pulse shorter than the debounce window, which a design with an off-by-one debounce would turn into a spurious mute-and-switch. It also measures the length of the muted interval, where a miscounted hold or an unmute that skips the mute-all step would show up as a busy width other than `MUTE_HOLD_CYC`, or as a pin rising straight from a mixed state. Finally it flips a polarity input on a steady pin, changes a jack in the middle of a sequence, and checks the routing right after reset with no jack edge. A design that only reacts to pin edges, or that throws away late changes, would be left with a stale mask.

// File: rtl/jack_route_pkg.sv
package jack_route_pkg;

    localparam int OUT_SPK = 0;
    localparam int OUT_HP  = 1;
    localparam int OUT_LO  = 2;
    localparam int N_OUTS  = 3;
    localparam int DET_HP  = 0;
    localparam int DET_LO  = 1;
    localparam int N_DETS  = 2;

    typedef logic [N_OUTS-1:0] route_mask_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_HOLD = 1'b1
    } seq_state_e;

    function automatic route_mask_t pick_route(input logic hp_in, input logic lo_in);
        route_mask_t m;
        m          = '0;
        m[OUT_HP]  = hp_in;
        m[OUT_LO]  = lo_in;
        m[OUT_SPK] = ~(hp_in | lo_in);
        return m;
    endfunction

endpackage

// File: rtl/det_conditioner.sv
module det_conditioner #(
    parameter int DEBOUNCE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_in,
    input  logic act_lvl,
    output logic present
);
    localparam int CW = $clog2(DEBOUNCE_CYC + 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic          level;
        logic [CW-1:0] cnt;
    } cond_t;

    cond_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.sync1 = raw_in;
        r_d.sync2 = r_q.sync1;
        if (r_q.sync2 != r_q.level) begin
            if (r_q.cnt == CW'(DEBOUNCE_CYC - 1)) begin
                r_d.level = r_q.sync2;
                r_d.cnt   = '0;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign present = (r_q.level == act_lvl);

    AST_DEBOUNCE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.level != $past(r_q.level)) |-> ($past(r_q.cnt) == CW'(DEBOUNCE_CYC - 1))); // R8
    AST_LEVEL_FOLLOWS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.level != $past(r_q.level)) |-> (r_q.level == $past(r_q.sync2))); // R8

endmodule

// File: rtl/route_sequencer.sv
module route_sequencer
    import jack_route_pkg::*;
#(
    parameter int MUTE_HOLD_CYC = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hp_present,
    input  logic        lo_present,
    output route_mask_t mask,
    output route_mask_t pins,
    output logic        busy
);
    localparam int HW = $clog2(MUTE_HOLD_CYC + 1);

    typedef struct packed {
        seq_state_e    state;
        logic [HW-1:0] cnt;
        route_mask_t   tgt;
        route_mask_t   mask;
        route_mask_t   pins;
        logic          busy;
    } seq_t;

    seq_t s_q, s_d;
    route_mask_t want;

    always_comb begin
        want = pick_route(hp_present, lo_present);
        s_d  = s_q;
        unique case (s_q.state)
            SEQ_IDLE: begin
                if (want != s_q.mask) begin
                    s_d.state = SEQ_HOLD;
                    s_d.cnt   = '0;
                    s_d.tgt   = want;
                    s_d.pins  = '0;
                    s_d.busy  = 1'b1;
                end
            end
            SEQ_HOLD: begin
                if (s_q.cnt == HW'(MUTE_HOLD_CYC - 1)) begin
                    s_d.state = SEQ_IDLE;
                    s_d.pins  = s_q.tgt;
                    s_d.mask  = s_q.tgt;
                    s_d.busy  = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
            default: s_d = s_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.state <= SEQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mask = s_q.mask;
    assign pins = s_q.pins;
    assign busy = s_q.busy;

    AST_FALLBACK_SPK: assert property (@(posedge clk) disable iff (!rst_n)
        (mask != '0) |-> (mask[OUT_SPK] == ~(mask[OUT_HP] | mask[OUT_LO]))); // R3
    AST_QUIET_WHEN_SAME: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && want == mask) |=> (!busy && $stable(pins))); // R4
    AST_MUTE_BEFORE_UNMUTE: assert property (@(posedge clk) disable iff (!rst_n)
        (pins != $past(pins)) && ((pins & ~$past(pins)) != '0) |-> ($past(pins) == '0)); // R5
    AST_ALL_MUTED_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (pins == '0)); // R5
    AST_MASK_AT_END_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (mask != $past(mask)) |-> ($past(busy) && !busy)); // R6
    AST_PINS_MATCH_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (pins == mask)); // R7

endmodule

// File: rtl/jack_route_ctrl.sv
module jack_route_ctrl
    import jack_route_pkg::*;
#(
    parameter int DEBOUNCE_CYC  = 8,
    parameter int MUTE_HOLD_CYC = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hp_det_raw,
    input  logic       lo_det_raw,
    input  logic       hp_act_lvl,
    input  logic       lo_act_lvl,
    output logic       spk_mute_n,
    output logic       hp_mute_n,
    output logic       lo_mute_n,
    output logic [2:0] route_mask,
    output logic       busy
);
    logic [N_DETS-1:0] raw_vec;
    logic [N_DETS-1:0] lvl_vec;
    logic [N_DETS-1:0] pres_vec;
    route_mask_t       mask_w;
    route_mask_t       pins_w;

    assign raw_vec[DET_HP] = hp_det_raw;
    assign raw_vec[DET_LO] = lo_det_raw;
    assign lvl_vec[DET_HP] = hp_act_lvl;
    assign lvl_vec[DET_LO] = lo_act_lvl;

    for (genvar g = 0; g < N_DETS; g++) begin : g_det
        det_conditioner #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_in  (raw_vec[g]),
            .act_lvl (lvl_vec[g]),
            .present (pres_vec[g])
        );
    end

    route_sequencer #(.MUTE_HOLD_CYC(MUTE_HOLD_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .hp_present (pres_vec[DET_HP]),
        .lo_present (pres_vec[DET_LO]),
        .mask       (mask_w),
        .pins       (pins_w),
        .busy       (busy)
    );

    assign spk_mute_n = pins_w[OUT_SPK];
    assign hp_mute_n  = pins_w[OUT_HP];
    assign lo_mute_n  = pins_w[OUT_LO];
    assign route_mask = mask_w;

endmodule

// File: tb/tb_jack_route_ctrl.sv
`timescale 1ns/1ps
module tb_jack_route_ctrl;
    localparam int DEB  = 8;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hp_raw = 1'b0, lo_raw = 1'b0, hp_act = 1'b1, lo_act = 1'b1;
    logic spk_n, hp_n, lo_n, busy;
    logic [2:0] mask;

    always #4 clk = ~clk;

    jack_route_ctrl #(.DEBOUNCE_CYC(DEB), .MUTE_HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .hp_det_raw(hp_raw), .lo_det_raw(lo_raw),
        .hp_act_lvl(hp_act), .lo_act_lvl(lo_act), .spk_mute_n(spk_n),
        .hp_mute_n(hp_n), .lo_mute_n(lo_n), .route_mask(mask), .busy(busy));

    int n_chk = 0, n_bad = 0;
    string cur_req = "R7";
    bit done = 0;

    // behavioural reference state
    int m_s1[2], m_s2[2], m_st[2], m_cnt[2];
    int m_mask, m_pins, m_busy, m_hold, m_tgt, m_inseq;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin
                m_s1[d] = 0; m_s2[d] = 0; m_st[d] = 0; m_cnt[d] = 0;
            end
            m_mask = 0; m_pins = 0; m_busy = 0; m_hold = 0; m_tgt = 0; m_inseq = 0;
        end else begin
            int act[2], raw[2], want;
            bit hp_on, lo_on;
            act[0] = int'(hp_act); act[1] = int'(lo_act);
            raw[0] = int'(hp_raw); raw[1] = int'(lo_raw);
            hp_on = (m_st[0] == act[0]);
            lo_on = (m_st[1] == act[1]);
            want = (hp_on ? 2 : 0) + (lo_on ? 4 : 0);
            if (want == 0) want = 1;
            if (m_inseq == 0) begin
                if (want != m_mask) begin
                    m_inseq = 1; m_hold = 0; m_tgt = want; m_pins = 0; m_busy = 1;
                end
            end else if (m_hold == HOLD - 1) begin
                m_inseq = 0; m_pins = m_tgt; m_mask = m_tgt; m_busy = 0;
            end else begin
                m_hold++;
            end
            for (int d = 0; d < 2; d++) begin
                if (m_s2[d] != m_st[d]) begin
                    if (m_cnt[d] == DEB - 1) begin m_st[d] = m_s2[d]; m_cnt[d] = 0; end
                    else m_cnt[d]++;
                end else m_cnt[d] = 0;
                m_s2[d] = m_s1[d];
                m_s1[d] = raw[d];
            end
        end
    end

    // per-cycle comparison against the reference
    int busy_cyc = 0, mix_during_busy = 0;
    always @(negedge clk) begin
        if (!done) begin
            int pins_now;
            pins_now = {29'd0, lo_n, hp_n, spk_n};
            check(int'(mask) == m_mask, cur_req, "route_mask vs model", int'(mask), m_mask);
            check(pins_now == m_pins, cur_req, "mute pins vs model", pins_now, m_pins);
            check(int'(busy) == m_busy, cur_req, "busy vs model", int'(busy), m_busy);
            if (busy) begin
                busy_cyc++;
                if (pins_now != 0) mix_during_busy++;
            end
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int pins_now;
        // reset state (R7)
        cur_req = "R7";
        wait_cyc(3);
        pins_now = {29'd0, lo_n, hp_n, spk_n};
        check(pins_now == 0 && mask == 3'd0 && busy == 1'b0, "R7", "reset state", pins_now, 0);
        rst_n = 1'b1;

        // R9: routing set with no jack edge; nothing plugged -> speaker (R3)
        cur_req = "R9";
        busy_cyc = 0;
        wait_cyc(1 + HOLD + 2);
        check(mask == 3'b001, "R9", "initial route without edge", int'(mask), 1);
        check(spk_n == 1'b1 && hp_n == 1'b0, "R3", "speaker fallback pins", int'(spk_n), 1);
        check(busy_cyc == HOLD, "R6", "busy width first sequence", busy_cyc, HOLD);

        // R2: headphone plugged
        cur_req = "R2";
        busy_cyc = 0; mix_during_busy = 0;
        hp_raw = 1'b1;
        wait_cyc(2 + DEB + HOLD + 6);
        check(mask == 3'b010, "R2", "headphone only", int'(mask), 2);
        check(busy_cyc == HOLD, "R6", "busy width", busy_cyc, HOLD);
        check(mix_during_busy == 0, "R5", "all muted while busy", mix_during_busy, 0);

        // R2: both plugged
        lo_raw = 1'b1;
        wait_cyc(2 + DEB + HOLD + 6);
        check(mask == 3'b110, "R2", "headphone and line-out", int'(mask), 6);
        check(lo_n == 1'b1 && hp_n == 1'b1 && spk_n == 1'b0, "R7", "pins follow mask", int'({lo_n, hp_n, spk_n}), 6);

        // R8 / R4: short glitch ignored, no busy activity
        cur_req = "R8";
        busy_cyc = 0;
        hp_raw = 1'b0;
        wait_cyc(DEB - 2);
        hp_raw = 1'b1;
        wait_cyc(DEB + HOLD + 10);
        check(mask == 3'b110, "R8", "short pulse ignored", int'(mask), 6);
        check(busy_cyc == 0, "R4", "no sequence while mask unchanged", busy_cyc, 0);

        // R1: polarity flip on steady pin
        cur_req = "R1";
        hp_act = 1'b0;
        wait_cyc(1 + HOLD + 3);
        check(mask == 3'b100, "R1", "polarity flip makes headphone absent", int'(mask), 4);

        // R3: line-out removed -> nothing plugged -> speaker
        cur_req = "R3";
        lo_raw = 1'b0;
        wait_cyc(2 + DEB + HOLD + 6);
        check(mask == 3'b001, "R3", "fallback after unplug", int'(mask), 1);

        // R10: change during sequence
        cur_req = "R10";
        lo_raw = 1'b1;
        wait_cyc(2 + DEB + 2);
        check(busy == 1'b1, "R10", "sequence in progress", int'(busy), 1);
        hp_act = 1'b1;
        wait_cyc(2 * HOLD + 6);
        check(mask == 3'b110, "R10", "late change picked up", int'(mask), 6);

        // R4: long idle window with no changes
        cur_req = "R4";
        busy_cyc = 0;
        wait_cyc(40);
        check(busy_cyc == 0, "R4", "idle stays quiet", busy_cyc, 0);

        finish_run();
    end
endmodule